// File: doc/BRIEF.md
# UART Modem Loopback Controller

This block implements the internal self-test path of a UART. While the loopback switch in the control word is on, the software-driven modem control outputs are wired back onto the modem status flags. The modem-status interrupt bits are rebuilt from those looped values. Every character written for transmission, and every rising edge of the send-break control, is placed straight into the receive FIFO at the character level. In the same mode, characters and break events from the external receive line are thrown away. While the switch is off, the modem status flags track the external modem lines, and only the external line feeds the receive FIFO.

The block contains a small receive FIFO. Each entry is one bit wider than a character, and that extra top bit marks a break. The host drains the FIFO through a pop strobe and sees the oldest entry on a read port. Serial framing and bit timing are outside this block. A control-word write takes effect on the modem flags one cycle later. For routing of transmit, break and external traffic, the loopback switch in use is always the registered value shown on `loop_o`.

Top module: `uart_loopback_ctl`

## Requirements
- R1: During reset `loop_o`, `modem_o`, `ms_clr_o` and `ms_set_o` are all zero, and the FIFO is empty with a count of zero.
- R2: Modem bit order in `modem_o`, `ext_modem_i` and `ms_set_o` is [0] ring, [1] clear-to-send, [2] carrier detect, [3] data-set-ready. A control write with the loopback bit set makes `modem_o` equal to {dtr, out1, rts, out2} on the next cycle. This holds even when the write only turns loopback on.
- R3: In the cycle after a control write with the loopback bit set, `ms_clr_o` pulses high to clear all four modem interrupt bits, and `ms_set_o` carries the looped flags that are to be set again. In every other cycle both are zero.
- R4: When the loopback state after a cycle is off, `modem_o` equals the `ext_modem_i` value sampled at that cycle's edge.
- R5: While loopback stays on and no control write occurs, `modem_o` holds its value, whatever `ext_modem_i` does.
- R6: With `loop_o` high, a transmit write pushes {1'b0, data} into the FIFO. With `loop_o` low, a transmit write pushes nothing.
- R7: With `loop_o` high, a break-control write that moves the stored send-break bit from 0 to 1 pushes the break entry (top bit 1, character bits 0). A write of 1 when the bit is already 1, a write of 0, or any break-control write with `loop_o` low pushes nothing.
- R8: External characters and external break events are discarded while `loop_o` is high. With `loop_o` low, an external character is pushed as {1'b0, data} and an external break is pushed as the break entry.
- R9: Only one entry is pushed per cycle. The priority, from highest, is: internal break, then transmit character, then external break, then external character.
- R10: A push into a full FIFO is dropped, and the count never exceeds DEPTH.
- R11: Entries leave in arrival order, and `rx_data_o` shows the oldest entry whenever the FIFO is non-empty. A pop on an empty FIFO has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_wr_i | input | 1 | Control word write strobe |
| ctrl_loop_i | input | 1 | Loopback enable field of the written control word |
| ctrl_out2_i | input | 1 | Out2 modem control field |
| ctrl_out1_i | input | 1 | Out1 modem control field |
| ctrl_rts_i | input | 1 | Request-to-send field |
| ctrl_dtr_i | input | 1 | Data-terminal-ready field |
| brk_wr_i | input | 1 | Line-control write strobe carrying the send-break bit |
| brk_val_i | input | 1 | Written send-break value |
| tx_wr_i | input | 1 | Transmit data write strobe |
| tx_data_i | input | DATA_W | Transmit character |
| ext_rx_valid_i | input | 1 | Character arriving from the external line |
| ext_rx_data_i | input | DATA_W | External character |
| ext_brk_i | input | 1 | Break event from the external line |
| ext_modem_i | input | 4 | External modem status lines |
| loop_o | output | 1 | Registered loopback state |
| modem_o | output | 4 | Modem status flags |
| ms_clr_o | output | 1 | Clear all modem interrupt bits |
| ms_set_o | output | 4 | Modem interrupt bits to set |
| rx_pop_i | input | 1 | Remove the oldest FIFO entry |
| rx_data_o | output | DATA_W+1 | Oldest FIFO entry, top bit marks a break |
| rx_empty_o | output | 1 | FIFO empty |
| rx_full_o | output | 1 | FIFO holds DEPTH entries |
| rx_count_o | output | clog2(DEPTH+1) | FIFO occupancy |

## Verification
The assertions assume strobes are single-cycle, synchronous inputs with known values after reset. The count-step properties assume a pop does not land in the cycle whose push they judge, so they are guarded by `rx_pop_i` low rather than trusting the design to order the two. The stimulus drives every input at the falling edge and holds it through the next rising edge. Random phases draw each strobe independently, so several push sources often collide in one cycle, and pops are drawn freely, including on an empty FIFO. The bench model applies the stated priority and full-drop rule to decide the expected outcome.

// File: rtl/uart_lbk_pkg.sv
package uart_lbk_pkg;

   localparam int MS_W = 4;

   typedef struct packed {
      logic lbk;
      logic out2;
      logic out1;
      logic rts;
      logic dtr;
   } lbk_ctrl_t;

   // index order: [0] ring, [1] clear-to-send, [2] carrier detect, [3] data-set-ready
   function automatic logic [MS_W-1:0] loop_modem(lbk_ctrl_t c);
      return {c.dtr, c.out1, c.rts, c.out2};
   endfunction

endpackage

// File: rtl/uart_lbk_modem.sv
module uart_lbk_modem
   import uart_lbk_pkg::*;
(
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            wr_i,
   input  lbk_ctrl_t       wdata_i,
   input  logic [MS_W-1:0] ext_i,
   output logic            loop_o,
   output logic [MS_W-1:0] modem_o,
   output logic            ms_clr_o,
   output logic [MS_W-1:0] ms_set_o
);

   logic            loop_q, loop_d;
   logic [MS_W-1:0] modem_q, looped;
   logic            remap;

   assign loop_d = wr_i ? wdata_i.lbk : loop_q;
   assign remap  = wr_i && wdata_i.lbk;
   assign looped = loop_modem(wdata_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         loop_q   <= 1'b0;
         modem_q  <= '0;
         ms_clr_o <= 1'b0;
         ms_set_o <= '0;
      end else begin
         loop_q   <= loop_d;
         ms_clr_o <= remap;
         ms_set_o <= remap ? looped : '0;
         if (remap)
            modem_q <= looped;
         else if (!loop_d)
            modem_q <= ext_i;
      end
   end

   assign loop_o  = loop_q;
   assign modem_o = modem_q;

   p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (loop_q && !wr_i) |=> $stable(modem_o));

   p_set_match_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ms_clr_o |-> (ms_set_o == modem_o));

   p_set_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ms_clr_o |-> (ms_set_o == '0));

endmodule

// File: rtl/uart_lbk_rxsel.sv
module uart_lbk_rxsel #(
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              loop_i,
   input  logic              brk_wr_i,
   input  logic              brk_val_i,
   input  logic              tx_wr_i,
   input  logic [DATA_W-1:0] tx_data_i,
   input  logic              ext_valid_i,
   input  logic [DATA_W-1:0] ext_data_i,
   input  logic              ext_brk_i,
   output logic              push_o,
   output logic [DATA_W:0]   push_data_o
);

   localparam int NSRC = 4;
   localparam logic [DATA_W:0] BRK_ENTRY = {1'b1, {DATA_W{1'b0}}};

   logic            brk_q;
   logic [NSRC-1:0] req, grant;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       brk_q <= 1'b0;
      else if (brk_wr_i) brk_q <= brk_val_i;
   end

   // index = priority rank, 0 highest
   assign req[0] = loop_i && brk_wr_i && brk_val_i && !brk_q;
   assign req[1] = loop_i && tx_wr_i;
   assign req[2] = !loop_i && ext_brk_i;
   assign req[3] = !loop_i && ext_valid_i;

   always_comb begin
      grant = '0;
      for (int i = 0; i < NSRC; i++)
         if (req[i] && grant == '0) grant[i] = 1'b1;
   end

   always_comb begin
      unique case (1'b1)
         grant[0], grant[2]: push_data_o = BRK_ENTRY;
         grant[1]:           push_data_o = {1'b0, tx_data_i};
         default:            push_data_o = {1'b0, ext_data_i};
      endcase
   end

   assign push_o = |grant;

   p_one_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(grant));

   p_ext_blocked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      loop_i |-> !(grant[2] || grant[3]));

endmodule

// File: rtl/uart_lbk_rxfifo.sv
module uart_lbk_rxfifo #(
   parameter int WIDTH = 9,
   parameter int DEPTH = 16,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             push_i,
   input  logic [WIDTH-1:0] push_data_i,
   input  logic             pop_i,
   output logic [WIDTH-1:0] data_o,
   output logic             empty_o,
   output logic             full_o,
   output logic [CNT_W-1:0] count_o
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("uart_lbk_rxfifo: DEPTH must be at least 2");
      end
      if (WIDTH < 2) begin : g_bad_width
         $error("uart_lbk_rxfifo: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] count_q;
   logic             push_ok, pop_ok;

   function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign full_o  = (count_q == CNT_W'(DEPTH));
   assign empty_o = (count_q == '0);
   assign push_ok = push_i && !full_o;
   assign pop_ok  = pop_i && !empty_o;

   always_ff @(posedge clk_i) begin
      if (push_ok) mem[wr_ptr] <= push_data_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count_q <= '0;
      end else begin
         if (push_ok) wr_ptr <= step(wr_ptr);
         if (pop_ok)  rd_ptr <= step(rd_ptr);
         count_q <= count_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
      end
   end

   assign data_o  = mem[rd_ptr];
   assign count_o = count_q;

   p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      count_q <= CNT_W'(DEPTH));

   p_full_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (full_o && push_i && !pop_i) |=> (full_o && $stable(rd_ptr)));

   p_empty_pop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (empty_o && pop_i && !push_i) |=> (empty_o && $stable(rd_ptr)));

endmodule

// File: rtl/uart_loopback_ctl.sv
module uart_loopback_ctl
   import uart_lbk_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic                         ctrl_wr_i,
   input  logic                         ctrl_loop_i,
   input  logic                         ctrl_out2_i,
   input  logic                         ctrl_out1_i,
   input  logic                         ctrl_rts_i,
   input  logic                         ctrl_dtr_i,
   input  logic                         brk_wr_i,
   input  logic                         brk_val_i,
   input  logic                         tx_wr_i,
   input  logic [DATA_W-1:0]            tx_data_i,
   input  logic                         ext_rx_valid_i,
   input  logic [DATA_W-1:0]            ext_rx_data_i,
   input  logic                         ext_brk_i,
   input  logic [3:0]                   ext_modem_i,
   output logic                         loop_o,
   output logic [3:0]                   modem_o,
   output logic                         ms_clr_o,
   output logic [3:0]                   ms_set_o,
   input  logic                         rx_pop_i,
   output logic [DATA_W:0]              rx_data_o,
   output logic                         rx_empty_o,
   output logic                         rx_full_o,
   output logic [$clog2(DEPTH+1)-1:0]   rx_count_o
);

   localparam int ENTRY_W = DATA_W + 1;

   generate
      if (DATA_W < 1) begin : g_bad_data_w
         $error("uart_loopback_ctl: DATA_W must be positive");
      end
   endgenerate

   lbk_ctrl_t         ctrl_w;
   logic              push;
   logic [DATA_W:0]   push_data;

   assign ctrl_w = '{lbk: ctrl_loop_i, out2: ctrl_out2_i, out1: ctrl_out1_i,
                     rts: ctrl_rts_i, dtr: ctrl_dtr_i};

   uart_lbk_modem u_modem (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (ctrl_wr_i),
      .wdata_i  (ctrl_w),
      .ext_i    (ext_modem_i),
      .loop_o   (loop_o),
      .modem_o  (modem_o),
      .ms_clr_o (ms_clr_o),
      .ms_set_o (ms_set_o)
   );

   uart_lbk_rxsel #(.DATA_W(DATA_W)) u_rxsel (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .loop_i      (loop_o),
      .brk_wr_i    (brk_wr_i),
      .brk_val_i   (brk_val_i),
      .tx_wr_i     (tx_wr_i),
      .tx_data_i   (tx_data_i),
      .ext_valid_i (ext_rx_valid_i),
      .ext_data_i  (ext_rx_data_i),
      .ext_brk_i   (ext_brk_i),
      .push_o      (push),
      .push_data_o (push_data)
   );

   uart_lbk_rxfifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .push_i      (push),
      .push_data_i (push_data),
      .pop_i       (rx_pop_i),
      .data_o      (rx_data_o),
      .empty_o     (rx_empty_o),
      .full_o      (rx_full_o),
      .count_o     (rx_count_o)
   );

   p_map_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_wr_i && ctrl_loop_i) |=>
      (modem_o == $past({ctrl_dtr_i, ctrl_out1_i, ctrl_rts_i, ctrl_out2_i})));

   p_follow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((ctrl_wr_i && !ctrl_loop_i) || (!ctrl_wr_i && !loop_o)) |=>
      (modem_o == $past(ext_modem_i)));

   p_tx_push_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (loop_o && tx_wr_i && !rx_full_o && !rx_pop_i) |=>
      (rx_count_o == $past(rx_count_o) + 1'b1));

   p_ext_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (loop_o && !tx_wr_i && !brk_wr_i && !rx_pop_i) |=> $stable(rx_count_o));

endmodule

// File: tb/uart_loopback_ctl_tb.sv
`timescale 1ns/1ps
module uart_loopback_ctl_tb;

   localparam int DW    = 8;
   localparam int DEPTH = 16;
   localparam int CW    = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n;
   logic          ctrl_wr, ctrl_loop, ctrl_out2, ctrl_out1, ctrl_rts, ctrl_dtr;
   logic          brk_wr, brk_val, tx_wr, ext_rx_valid, ext_brk, rx_pop;
   logic [DW-1:0] tx_data, ext_rx_data;
   logic [3:0]    ext_modem;
   logic          loop_o, ms_clr, rx_empty, rx_full;
   logic [3:0]    modem, ms_set;
   logic [DW:0]   rx_data;
   logic [CW-1:0] rx_count;

   uart_loopback_ctl #(.DATA_W(DW), .DEPTH(DEPTH)) u_dut (
      .clk_i(clk), .rst_ni(rst_n),
      .ctrl_wr_i(ctrl_wr), .ctrl_loop_i(ctrl_loop), .ctrl_out2_i(ctrl_out2),
      .ctrl_out1_i(ctrl_out1), .ctrl_rts_i(ctrl_rts), .ctrl_dtr_i(ctrl_dtr),
      .brk_wr_i(brk_wr), .brk_val_i(brk_val), .tx_wr_i(tx_wr), .tx_data_i(tx_data),
      .ext_rx_valid_i(ext_rx_valid), .ext_rx_data_i(ext_rx_data), .ext_brk_i(ext_brk),
      .ext_modem_i(ext_modem), .loop_o(loop_o), .modem_o(modem), .ms_clr_o(ms_clr),
      .ms_set_o(ms_set), .rx_pop_i(rx_pop), .rx_data_o(rx_data), .rx_empty_o(rx_empty),
      .rx_full_o(rx_full), .rx_count_o(rx_count)
   );

   int    checks = 0, errors = 0;
   bit    done = 1'b0;
   string ph = "R1";
   string mtag = "R1";

   // reference model state
   bit          m_loop, m_brk, m_clr;
   bit [3:0]    m_modem, m_set;
   logic [DW:0] q[$];

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic void model_step();
      bit ib, it, eb, ec, nl, was_full;
      logic [DW:0] ent;
      ib = m_loop && brk_wr && brk_val && !m_brk;
      it = m_loop && tx_wr;
      eb = !m_loop && ext_brk;
      ec = !m_loop && ext_rx_valid;
      ent = ib || (!it && eb) ? {1'b1, {DW{1'b0}}} : it ? {1'b0, tx_data} : {1'b0, ext_rx_data};
      was_full = (q.size() == DEPTH);
      if (rx_pop && q.size() > 0) void'(q.pop_front());
      if ((ib || it || eb || ec) && !was_full) q.push_back(ent);
      nl = ctrl_wr ? ctrl_loop : m_loop;
      if (ctrl_wr && ctrl_loop) begin
         m_modem = {ctrl_dtr, ctrl_out1, ctrl_rts, ctrl_out2};
         m_clr = 1'b1; m_set = m_modem; mtag = "R2";
      end else begin
         m_clr = 1'b0; m_set = 4'h0;
         if (!nl) begin m_modem = ext_modem; mtag = "R4"; end
         else mtag = "R5";
      end
      m_loop = nl;
      if (brk_wr) m_brk = brk_val;
   endfunction

   task automatic compare();
      chk(mtag, "modem", modem, m_modem);
      chk(mtag, "loop", loop_o, m_loop);
      chk("R3", "ms_clr", ms_clr, m_clr);
      chk("R3", "ms_set", ms_set, m_set);
      chk(ph, "count", rx_count, q.size());
      chk(ph, "empty", rx_empty, q.size() == 0);
      chk("R10", "full", rx_full, q.size() == DEPTH);
      if (q.size() > 0) chk("R11", "head", rx_data, q[0]);
   endtask

   task automatic clear_strobes();
      ctrl_wr = 0; brk_wr = 0; tx_wr = 0; ext_rx_valid = 0; ext_brk = 0; rx_pop = 0;
   endtask

   task automatic cyc();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
      clear_strobes();
   endtask

   task automatic ctrl(bit l, bit o2, bit o1, bit r, bit d);
      ctrl_wr = 1; ctrl_loop = l; ctrl_out2 = o2; ctrl_out1 = o1; ctrl_rts = r; ctrl_dtr = d;
      cyc();
   endtask

   initial begin
      rst_n = 0;
      ctrl_loop = 0; ctrl_out2 = 0; ctrl_out1 = 0; ctrl_rts = 0; ctrl_dtr = 0;
      brk_val = 0; tx_data = '0; ext_rx_data = '0; ext_modem = 4'h0;
      clear_strobes();
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1", "loop", loop_o, 0);
      chk("R1", "modem", modem, 0);
      chk("R1", "ms_clr", ms_clr, 0);
      chk("R1", "ms_set", ms_set, 0);
      chk("R1", "count", rx_count, 0);
      chk("R1", "empty", rx_empty, 1);
      rst_n = 1;
      m_loop = 0; m_brk = 0; m_clr = 0; m_modem = 0; m_set = 0;

      // R4: external modem lines followed outside loopback
      ext_modem = 4'hA; cyc();
      ext_modem = 4'h5; cyc();
      // R2: write that only enables loopback, all controls zero
      ctrl(1, 0, 0, 0, 0);
      // R2: mapping with distinct pattern out2=1 out1=0 rts=1 dtr=0 -> 4'b0011
      ctrl(1, 1, 0, 1, 0);
      ctrl(1, 0, 1, 0, 1);
      // R5: hold while external lines move
      ext_modem = 4'hF; cyc(); cyc();
      // R6: transmit writes looped back
      ph = "R6";
      tx_wr = 1; tx_data = 8'h41; cyc();
      tx_wr = 1; tx_data = 8'hC3; cyc();
      // R7: break rising edge, then repeated 1 and a clear
      ph = "R7";
      brk_wr = 1; brk_val = 1; cyc();
      brk_wr = 1; brk_val = 1; cyc();
      brk_wr = 1; brk_val = 0; cyc();
      // R8: external traffic discarded in loopback
      ph = "R8";
      ext_rx_valid = 1; ext_rx_data = 8'h77; cyc();
      ext_brk = 1; cyc();
      // R9: break edge and transmit collide -> break entry only
      ph = "R9";
      brk_wr = 1; brk_val = 1; tx_wr = 1; tx_data = 8'h99; cyc();
      // leave loopback, external lines return (R4)
      ctrl(0, 1, 1, 1, 1);
      ph = "R8";
      ext_rx_valid = 1; ext_rx_data = 8'h12; cyc();
      ext_brk = 1; cyc();
      ph = "R6";
      tx_wr = 1; tx_data = 8'h55; cyc();
      // R7: break edge outside loopback pushes nothing
      ph = "R7";
      brk_wr = 1; brk_val = 0; cyc();
      brk_wr = 1; brk_val = 1; cyc();
      // R9: external break beats external character
      ph = "R9";
      ext_brk = 1; ext_rx_valid = 1; ext_rx_data = 8'h3C; cyc();
      // R11: drain all, then pop empty
      ph = "R11";
      while (q.size() > 0) begin rx_pop = 1; cyc(); end
      rx_pop = 1; cyc();
      // R10: fill past depth
      ph = "R10";
      for (int i = 0; i < DEPTH + 3; i++) begin
         ext_rx_valid = 1; ext_rx_data = DW'(i + 8'h20); cyc();
      end
      ph = "R11";
      for (int i = 0; i < DEPTH + 1; i++) begin rx_pop = 1; cyc(); end

      // random mix with fixed seed
      void'($urandom(32'h1234_5678));
      for (int i = 0; i < 4000; i++) begin
         ctrl_wr      = ($urandom % 8) == 0;
         ctrl_loop    = ($urandom % 3) != 0;
         {ctrl_out2, ctrl_out1, ctrl_rts, ctrl_dtr} = 4'($urandom);
         brk_wr       = ($urandom % 6) == 0;
         brk_val      = $urandom % 2;
         tx_wr        = ($urandom % 3) == 0;
         tx_data      = DW'($urandom);
         ext_rx_valid = ($urandom % 3) == 0;
         ext_rx_data  = DW'($urandom);
         ext_brk      = ($urandom % 10) == 0;
         rx_pop       = ($urandom % 3) == 0;
         if (($urandom % 5) == 0) ext_modem = 4'($urandom);
         ph = "R9";
         cyc();
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule